// File: doc/BRIEF.md
# Input Ordering Detector

This block watches two level inputs and decides which of them became active first. One input, `leadIn`, is the one expected to arrive first. The other, `lagIn`, is expected to follow. If `leadIn` is seen while `lagIn` is still low, the detector arms itself. When `lagIn` is seen after that, it raises `passOut` and holds it high until reset. If `lagIn` shows up first, or both inputs rise in the same clock cycle, the detector locks into a failed state with `passOut` low until reset.

The block is a Moore machine with four states held in two flip-flops. `passOut` is decoded from the state register alone, so it never follows the inputs within a cycle. A change on the inputs reaches `passOut` after one clock edge. The inputs must already be synchronous to `clk`. No debouncing or synchronizing is done inside the block.

The design splits into two parts under a thin top. A control part turns the current state and the inputs into transition strobes. A datapath part holds the state register and decodes the output.

Top module: `order_first_detect`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the state returns to idle (code 00) from any state, and `passOut` reads 0 after that edge.
- R2: In idle, an edge with `leadIn`=0 and `lagIn`=0 leaves the machine in idle. A later lead-then-lag sequence still passes.
- R3: In idle, an edge with `leadIn`=1 and `lagIn`=0 moves to the armed state (code 01). `passOut` stays 0.
- R4: In idle, an edge with `leadIn`=0 and `lagIn`=1 moves to the failed state (code 10).
- R5: In idle, an edge with both `leadIn`=1 and `lagIn`=1 counts as lag-first and moves to the failed state (code 10).
- R6: In the armed state, any edge with `lagIn`=1 moves to the passed state (code 11), whatever the value of `leadIn`.
- R7: In the armed state, an edge with `lagIn`=0 stays armed, whether `leadIn` is still high or has dropped.
- R8: The failed state holds for every input combination until reset. `passOut` stays 0 and a later lead-then-lag sequence does not pass.
- R9: The passed state holds for every input combination until reset, with `passOut` at 1.
- R10: `passOut` is 1 only in the passed state and depends on the state register alone. It changes only after a clock edge, one edge after the input that caused the transition was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| leadIn | input | 1 | Input that must become active first for a pass |
| lagIn | input | 1 | Input that must become active second for a pass |
| passOut | output | 1 | High while the machine is in the passed state |

## Verification
The assertions assume that `leadIn`, `lagIn` and `rst` are synchronous to `clk` and settle well before each rising edge. Every property therefore reads an input value as the one sampled at that edge. The bench meets this assumption by changing all inputs on the falling edge only. It reads `passOut` one time unit after each rising edge. It sweeps every input sequence of up to four cycles from reset and then applies one of two probe sequences. Between them, the two probes tell idle, armed, failed and passed apart through `passOut` alone.

// File: rtl/order_first_pkg.sv
package order_first_pkg;

  // State codes: one bit pattern per state, passed = 11 so the output is a plain AND.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SEEN_A = 2'b01,
    ST_FAILED = 2'b10,
    ST_PASSED = 2'b11
  } ordState_t;

  localparam int STATE_W = $bits(ordState_t);

  // Transition requests from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic goSeenA;
    logic goFail;
    logic goPass;
  } ordStrobe_t;

endpackage

// File: rtl/order_first_ctrl.sv
module order_first_ctrl
  import order_first_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ordState_t  curState,
  input  logic       leadIn,
  input  logic       lagIn,
  output ordStrobe_t strobe
);

  // Only idle and armed can leave; the lock states never receive a strobe.
  always_comb begin
    strobe = '0;
    unique case (curState)
      ST_IDLE: begin
        if (lagIn)       strobe.goFail  = 1'b1;  // lag first or both together
        else if (leadIn) strobe.goSeenA = 1'b1;
      end
      ST_SEEN_A: begin
        if (lagIn)       strobe.goPass  = 1'b1;
      end
      default: ;
    endcase
  end

  // R2
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_IDLE && !leadIn && !lagIn) |=> (curState == ST_IDLE));

  // R3
  p_lead_arms_r3: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_IDLE && leadIn && !lagIn) |=> (curState == ST_SEEN_A));

  // R4 and R5: lag seen in idle, with or without lead
  p_lag_first_fails_r4: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_IDLE && lagIn) |=> (curState == ST_FAILED));

  // R6
  p_lag_after_lead_r6: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_SEEN_A && lagIn) |=> (curState == ST_PASSED));

  // R7
  p_armed_waits_r7: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_SEEN_A && !lagIn) |=> (curState == ST_SEEN_A));

endmodule

// File: rtl/order_first_dp.sv
module order_first_dp
  import order_first_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ordStrobe_t strobe,
  output ordState_t  curState,
  output logic       passOut
);

  ordState_t nextState;

  always_comb begin
    nextState = curState;
    if (strobe.goPass)       nextState = ST_PASSED;
    else if (strobe.goFail)  nextState = ST_FAILED;
    else if (strobe.goSeenA) nextState = ST_SEEN_A;
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end

  // Moore output: both state bits set only in the passed code.
  assign passOut = curState[STATE_W-1] & curState[0];

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (curState == ST_IDLE && !passOut));

  // R8
  p_failed_sticks_r8: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_FAILED) |=> (curState == ST_FAILED && !passOut));

  // R9
  p_passed_sticks_r9: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_PASSED) |=> (curState == ST_PASSED && passOut));

  // R10: output rises only on the edge leaving the armed state
  p_out_rise_from_armed_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(passOut) |-> ($past(curState) == ST_SEEN_A));

  // Strobes are mutually exclusive
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.goSeenA, strobe.goFail, strobe.goPass}));

endmodule

// File: rtl/order_first_detect.sv
module order_first_detect
  import order_first_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic leadIn,
  input  logic lagIn,
  output logic passOut
);

  ordState_t  curState;
  ordStrobe_t strobe;

  order_first_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .curState (curState),
    .leadIn   (leadIn),
    .lagIn    (lagIn),
    .strobe   (strobe)
  );

  order_first_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState),
    .passOut  (passOut)
  );

endmodule

// File: tb/order_first_detect_tb.sv
module order_first_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int MAX_LEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic leadIn = 1'b0;
  logic lagIn = 1'b0;
  logic passOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Bench model: 0 idle, 1 armed, 2 failed, 3 passed
  int model = 0;

  order_first_detect u_dut (
    .clk     (clk),
    .rst     (rst),
    .leadIn  (leadIn),
    .lagIn   (lagIn),
    .passOut (passOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int modelNext(input int s, input bit ld, input bit lg);
    case (s)
      0:       modelNext = lg ? 2 : (ld ? 1 : 0);
      1:       modelNext = lg ? 3 : 1;
      default: modelNext = s;
    endcase
  endfunction

  function automatic string reqTag(input int s, input bit ld, input bit lg);
    case (s)
      0:       reqTag = (ld && lg) ? "R5" : (lg ? "R4" : (ld ? "R3" : "R2"));
      1:       reqTag = lg ? "R6" : "R7";
      2:       reqTag = "R8";
      default: reqTag = "R9";
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      summary();
    end
  end

  task automatic check(input string tag, input bit expOut);
    checks++;
    if (passOut !== expOut) begin
      failures++;
      $display("FAIL %s/R10 passOut=%0b expected %0b", tag, passOut, expOut);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; leadIn = 1'b1; lagIn = 1'b1;
    @(posedge clk); #1;
    model = 0;
    check("R1", 1'b0);
    @(negedge clk);
    rst = 1'b0; leadIn = 1'b0; lagIn = 1'b0;
  endtask

  task automatic step(input bit ld, input bit lg);
    string tag;
    @(negedge clk);
    leadIn = ld; lagIn = lg;
    tag = reqTag(model, ld, lg);
    model = modelNext(model, ld, lg);
    @(posedge clk); #1;
    check(tag, model == 3);
  endtask

  initial begin
    // Reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1", 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Directed: lead then lag, lead drops before lag, sticky after inputs change
    doReset();
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1);
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
    // Directed: lag first, then a proper sequence must not pass (R8)
    doReset();
    step(1'b0, 1'b1); step(1'b1, 1'b0); step(1'b0, 1'b1);
    // Directed: both together (R5)
    doReset();
    step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b0, 1'b1);

    // Exhaustive sweep of short sequences followed by a distinguishing probe
    for (int len = 0; len <= MAX_LEN; len++) begin
      for (int code = 0; code < (1 << (2 * len)); code++) begin
        for (int probe = 0; probe < 2; probe++) begin
          doReset();
          for (int i = 0; i < len; i++) begin
            int pair;
            pair = (code >> (2 * i)) & 3;
            step(pair[1], pair[0]);
          end
          if (probe == 0) begin
            step(1'b1, 1'b1);  // passes only from armed or passed
            step(1'b0, 1'b0);
          end else begin
            step(1'b1, 1'b0);  // idle arms, then lag passes
            step(1'b0, 1'b1);
            step(1'b0, 1'b0);
          end
        end
      end
    end

    // Reset out of passed state, then idle behaviour again (R1, R2)
    doReset();
    step(1'b1, 1'b0); step(1'b0, 1'b1);
    doReset();
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);

    summary();
  end

endmodule